// File: doc/BRIEF.md
# Serial Transmitter with Queued Break Characters

This block is the sending half of an asynchronous serial port. Software puts one character into a single-entry holding slot. A shift register then sends it as a start bit, eight data bits with the least significant bit first, an optional ninth bit, and a stop bit. The line rests at logic 1. A separate bit-rate generator sets the pace through a one-cycle `bit_tick` strobe, and each strobe moves the line on to the next bit.

Software sends a break by setting a control bit. Break characters are low for a whole frame, stop position included. They do not bypass the data path: they take the same holding slot and the same shift register as data. As a result, setting and then clearing the bit on a quiet transmitter sends two breaks. The first one goes straight into the shifter, and the second is already waiting in the slot. Once the last break has gone out, the line is driven high for one bit time before any data character starts.

Software sees two flags: buffer empty and transmission complete. The buffer-empty flag clears only when software reads the status register while the flag is set and then writes the data register. Both flags can request an interrupt.

Top module: `sertx_core`

## Requirements
- R1: After reset, status bit 7 (buffer empty) and bit 6 (complete) read 1, all other status bits read 0, `txd` is 1 and `irq` is 0.
- R2: A data character is sent as one 0 start bit, then data bits 0..7, then, in nine-bit mode, the ninth bit taken from control bit 4 at the time of the data write, then one 1 stop bit. The line moves to the next bit on each `bit_tick`.
- R3: A write to the data register (address 1) is accepted only if the last status read (address 0) since the previous data write saw buffer-empty set, and buffer-empty is still set at the time of the write. An accepted write clears buffer-empty. Any other data write is ignored, and nothing is sent for it.
- R4: Buffer-empty sets again when the held character moves into the shift register. That move happens at once when the shifter is idle, or at the last bit time of the current frame.
- R5: Complete reads 1 only when the shifter is idle, the slot is empty and the break control bit is clear. While it reads 1, `txd` is 1.
- R6: A break character holds `txd` at 0 for the full frame length: 10 bit times in eight-bit mode and 11 bit times in nine-bit mode.
- R7: On an idle transmitter, holding the break bit (control bit 0) for at least four clock cycles and clearing it before the first break ends sends exactly two break characters.
- R8: After the last break of a run, `txd` stays at 1 for at least one bit time before the start bit of the next data character.
- R9: `irq` is 1 when buffer-empty is set with control bit 2 set, or when complete is set with control bit 3 set.
- R10: Register addresses are 0 for status, 1 for data (write only) and 2 for control. The control register holds break (bit 0), nine-bit mode (bit 1), empty interrupt enable (bit 2), complete interrupt enable (bit 3) and the ninth data bit (bit 4), and reads back as written in bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe that advances the line by one bit |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a status read arms the data write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The bench decodes the line at every tick and compares each frame, in order, with characters it predicted. This catches a wrong bit order, a ninth bit latched at the wrong moment, and a data write accepted without the status read, which would show up as an extra frame. Quiet-line breaks must produce exactly two all-zero frames of the mode's length. A design that fails to queue the second break sends one frame, and a design that keeps re-queuing breaks sends a third. A data character sent straight after a break must follow at least one high bit time; without it, the start bit would merge into the break. Status reads made just after a handshake check that buffer-empty comes back once the shifter takes the character, and that complete drops for the whole frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int CNT_W     = $clog2(FRAME_MAX);
    localparam int ADDR_W    = 2;
    localparam int BUS_W     = 8;

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    // control register, bit 4 down to bit 0
    typedef struct packed {
        logic tx_b8;
        logic tc_ie;
        logic tdre_ie;
        logic nine;
        logic brk;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // content of the single holding slot
    typedef struct packed {
        logic            is_brk;
        logic [DATA_W:0] data;
    } slot_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SEND,
        SH_GUARD
    } sh_state_e;

    function automatic logic [CNT_W-1:0] frame_len(input logic nine);
        return nine ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
    endfunction

    // line image of one frame, bit 0 goes out first
    function automatic logic [FRAME_MAX-1:0] frame_of(input slot_t s, input logic nine);
        logic [FRAME_MAX-1:0] f;
        f = '1;
        if (s.is_brk) begin
            f = '0;
        end else begin
            f[0]        = 1'b0;
            f[DATA_W:1] = s.data[DATA_W-1:0];
            if (nine) f[DATA_W+1] = s.data[DATA_W];
        end
        return f;
    endfunction

    function automatic logic [BUS_W-1:0] status_byte(input logic empty, input logic done);
        return {empty, done, {(BUS_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              tdre,
    input  logic              tc,
    output ctl_t              ctl,
    output logic              wr_ok,
    output logic [DATA_W:0]   wr_word,
    output logic [BUS_W-1:0]  rdata
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            ctl   <= '0;
        end else begin
            if (bus_wr && bus_addr == A_DATA)
                armed <= 1'b0;
            else if (bus_rd && bus_addr == A_STAT)
                armed <= tdre;
            if (bus_wr && bus_addr == A_CTRL)
                ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
        end
    end

    assign wr_ok   = bus_wr && (bus_addr == A_DATA) && armed && tdre;
    assign wr_word = {ctl.tx_b8, bus_wdata[DATA_W-1:0]};

    always_comb begin
        case (bus_addr)
            A_STAT:  rdata = status_byte(tdre, tc);
            A_CTRL:  rdata = {{(BUS_W-CTL_W){1'b0}}, ctl};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ok,
    input  logic [DATA_W:0] wr_word,
    input  logic            brk_req,
    input  logic            take,
    output logic            full,
    output slot_t           slot,
    output logic            tdre
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            slot <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_ok) begin
            full        <= 1'b1;
            slot.is_brk <= 1'b0;
            slot.data   <= wr_word;
        end else if (brk_req && !full) begin
            full        <= 1'b1;
            slot.is_brk <= 1'b1;
            slot.data   <= '0;
        end
    end

    assign tdre = !full;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_tick,
    input  logic  nine,
    input  logic  full,
    input  slot_t slot,
    output logic  take,
    output logic  idle,
    output logic  txd
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    sh_state_e             st;
    logic [FRAME_MAX-1:0]  shr;
    logic [CNT_W-1:0]      cnt;
    logic                  cur_brk;
    logic                  last_bit;

    assign last_bit = bit_tick && (cnt == '0);

    always_comb begin
        case (st)
            SH_IDLE:  take = full;
            SH_SEND:  take = last_bit && full && !(cur_brk && !slot.is_brk);
            SH_GUARD: take = bit_tick && full;
            default:  take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            shr     <= '1;
            cnt     <= '0;
            cur_brk <= 1'b0;
        end else if (take) begin
            st      <= SH_SEND;
            shr     <= frame_of(slot, nine);
            cnt     <= frame_len(nine) - ONE;
            cur_brk <= slot.is_brk;
        end else begin
            case (st)
                SH_SEND: begin
                    if (last_bit) begin
                        st <= cur_brk ? SH_GUARD : SH_IDLE;
                    end else if (bit_tick) begin
                        shr <= {1'b1, shr[FRAME_MAX-1:1]};
                        cnt <= cnt - ONE;
                    end
                end
                SH_GUARD: if (bit_tick) st <= SH_IDLE;
                default:  st <= SH_IDLE;
            endcase
        end
    end

    assign idle = (st == SH_IDLE);
    assign txd  = (st == SH_SEND) ? shr[0] : 1'b1;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txd,
    output logic              irq
);

    ctl_t            ctl_w;
    logic            wr_ok_w;
    logic [DATA_W:0] wr_word_w;
    logic            full_w;
    slot_t           slot_w;
    logic            tdre_w;
    logic            tc_w;
    logic            take_w;
    logic            idle_w;
    logic            brk_w;

    assign brk_w = ctl_w.brk;

    sertx_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .tdre      (tdre_w),
        .tc        (tc_w),
        .ctl       (ctl_w),
        .wr_ok     (wr_ok_w),
        .wr_word   (wr_word_w),
        .rdata     (bus_rdata)
    );

    sertx_hold i_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok_w),
        .wr_word (wr_word_w),
        .brk_req (brk_w),
        .take    (take_w),
        .full    (full_w),
        .slot    (slot_w),
        .tdre    (tdre_w)
    );

    sertx_shift i_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .nine     (ctl_w.nine),
        .full     (full_w),
        .slot     (slot_w),
        .take     (take_w),
        .idle     (idle_w),
        .txd      (txd)
    );

    assign tc_w = idle_w && !full_w && !brk_w;
    assign irq  = (tdre_w && ctl_w.tdre_ie) || (tc_w && ctl_w.tc_ie);

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic tdre,
    input logic tc,
    input logic wr_ok,
    input logic brk_req
);

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (tdre && tc && txd));

    // R5
    tc_line_mark_chk: assert property (@(posedge clk) disable iff (rst) tc |-> txd);

    // R5
    tc_slot_empty_chk: assert property (@(posedge clk) disable iff (rst) tc |-> tdre);

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(tdre) |-> !txd);

    // R3
    tdre_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tdre) |-> $past(wr_ok || brk_req));

endmodule

bind sertx_core sertx_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .txd     (txd),
    .tdre    (tdre_w),
    .tc      (tc_w),
    .wr_ok   (wr_ok_w),
    .brk_req (brk_w)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;

    localparam int TP = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       txd;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [9:0] exp_q[$];
    logic       nine_mode = 1'b0;
    logic [4:0] ctl_img = '0;

    always #2.5 clk = ~clk;

    sertx_core i_sertx_core (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .txd(txd), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_bits(input logic [9:0] e, input logic nine);
        logic [10:0] f;
        int len;
        len = nine ? 11 : 10;
        f = '1;
        for (int i = 0; i < len; i++) begin
            if (e[9])             f[i] = 1'b0;
            else if (i == 0)      f[i] = 1'b0;
            else if (i <= 8)      f[i] = e[i-1];
            else if (i == len-1)  f[i] = 1'b1;
            else                  f[i] = e[8];
        end
        return f;
    endfunction

    // tick generator, one pulse every TP cycles
    initial begin
        forever begin
            repeat (TP - 1) @(posedge clk);
            #1 bit_tick = 1'b1;
            @(posedge clk);
            #1 bit_tick = 1'b0;
        end
    end

    // line decoder, samples before each tick edge
    bit          in_frame = 1'b0;
    int          fidx = 0;
    int          flen = 10;
    int          gap = 0;
    bit          prev_brk = 1'b0;
    logic [10:0] fbits;

    always @(negedge clk) begin
        if (!rst && bit_tick) begin
            if (!in_frame) begin
                if (txd == 1'b0) begin
                    in_frame = 1'b1;
                    fbits = '1;
                    fbits[0] = 1'b0;
                    fidx = 1;
                    flen = nine_mode ? 11 : 10;
                end else begin
                    gap++;
                end
            end else begin
                fbits[fidx] = txd;
                fidx++;
                if (fidx == flen) begin
                    logic [9:0] e;
                    bit is_brk;
                    in_frame = 1'b0;
                    is_brk = (fbits[flen-1] == 1'b0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected frame", int'(fbits), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(fbits == exp_bits(e, nine_mode), e[9] ? "R6 break frame" : "R2 data frame",
                            int'(fbits), int'(exp_bits(e, nine_mode)));
                    end
                    if (!is_brk && prev_brk)
                        chk(gap > 0, "R8 mark before data after break", gap, 1);
                    prev_brk = is_brk;
                    gap = 0;
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic set_ctl(input logic [4:0] c);
        ctl_img = c;
        bus_write(2'd2, {3'b000, c});
    endtask

    task automatic wait_empty();
        logic [7:0] s;
        int n = 0;
        s = '0;
        while (!s[7] && n < 2000) begin
            bus_read(2'd0, s);
            n++;
        end
        chk(s[7] == 1'b1, "R4 buffer empty returns", s, 8'h80);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        s = '0;
        while (!s[6] && n < 4000) begin
            bus_read(2'd0, s);
            n++;
        end
        chk(s[6] == 1'b1, "R5 complete returns", s, 8'h40);
        repeat (3 * TP) @(posedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        wait_empty();
        exp_q.push_back({1'b0, ctl_img[4], d});
        bus_write(2'd1, d);
    endtask

    initial begin
        logic [7:0] s;
        void'($urandom(32'd20251));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(irq == 1'b0, "R1 irq low", irq, 0);

        // R3 write with no prior status read is dropped
        bus_write(2'd1, 8'h99);
        repeat (30 * TP) @(posedge clk);
        bus_read(2'd0, s);
        chk(s == 8'hC0, "R1 R3 status after reset and stray write", s, 8'hC0);

        // R9 R10 control readback and complete interrupt
        set_ctl(5'b01000);
        bus_read(2'd2, s);
        chk(s == 8'h08, "R10 control readback", s, 8'h08);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq from complete", irq, 1);

        // handshake and back-to-back
        send(8'h3C);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq low while sending", irq, 0);
        bus_read(2'd0, s);
        chk(s == 8'h80, "R4 empty set after move, R5 complete low", s, 8'h80);
        exp_q.push_back({1'b0, 1'b0, 8'h5A});
        bus_write(2'd1, 8'h5A);
        bus_write(2'd1, 8'h77);
        bus_read(2'd0, s);
        chk(s == 8'h00, "R3 accepted write clears empty", s, 8'h00);
        set_ctl(5'b00100);
        @(negedge clk);
        chk(irq == 1'b0, "R9 empty irq off while slot full", irq, 0);
        wait_idle();
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq from empty", irq, 1);
        set_ctl(5'b00000);

        // R7 break toggled on quiet line, eight-bit mode
        set_ctl(5'b00001);
        exp_q.push_back(10'h200);
        exp_q.push_back(10'h200);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(txd == 1'b0, "R6 break drives line low", txd, 0);
        bus_read(2'd0, s);
        chk(s[6] == 1'b0, "R5 complete low during break", s, 8'h00);
        set_ctl(5'b00000);
        wait_idle();
        chk(exp_q.size() == 0, "R7 two breaks sent", exp_q.size(), 0);

        // R8 break followed by data
        set_ctl(5'b00001);
        exp_q.push_back(10'h200);
        exp_q.push_back(10'h200);
        repeat (4) @(posedge clk);
        set_ctl(5'b00000);
        send(8'hA5);
        wait_idle();

        // R6 nine-bit break and nine-bit data
        nine_mode = 1'b1;
        set_ctl(5'b00011);
        exp_q.push_back(10'h200);
        exp_q.push_back(10'h200);
        repeat (4) @(posedge clk);
        set_ctl(5'b00010);
        wait_idle();
        set_ctl(5'b10010);
        send(8'h01);
        set_ctl(5'b00010);
        send(8'hFE);
        wait_idle();

        // random batches
        for (int b = 0; b < 6; b++) begin
            nine_mode = 1'($urandom_range(0, 1));
            set_ctl({1'b0, 2'b00, nine_mode, 1'b0});
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = 8'($urandom);
                set_ctl({1'($urandom_range(0, 1)), 2'b00, nine_mode, 1'b0});
                send(d);
                if ($urandom_range(0, 9) < 3) bus_write(2'd1, ~d);
                repeat ($urandom_range(0, 40)) @(posedge clk);
            end
            wait_idle();
        end

        chk(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule